// File: doc/BRIEF.md
# Thermal Pipeline-Switch Scheduler

This controller decides which of two execution pipelines services instructions, using two temperature readings. One pipeline is a wide, fast primary pipeline. The other is a small, low-power in-order secondary pipeline. While the primary pipeline stays under a programmable high limit, it runs and the secondary pipeline is clock-gated. When the primary pipeline reaches the high limit, the controller stalls fetch and requests a flush. It waits for a drained indication and then hands execution to the secondary pipeline. The primary pipeline can then cool with its clock gated.

Execution returns to the primary pipeline once its temperature has fallen to the low limit, so the two limits form a hysteresis band. The secondary pipeline can also heat up to the high limit while the primary pipeline is still warm. In that case the controller falls back to a whole-core throttle state and issues a 2-bit performance-level request. A build parameter chooses between a full clock stop and a scaled frequency step. The throttle state is left only when both readings are at or below the low limit.

Temperatures and limits are unsigned whole degrees Celsius. Typical settings are a low limit of 55 with a high limit of 70 (gentle) or 60 (aggressive). The limits are captured during reset and while running on the primary pipeline, and they are held at all other times. Every output is registered.

Top module: `thermal_pipe_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after its release, the outputs are `fetch_stall`=0, `flush_req`=0, `pipe_sel`=0, `clk_en_pri`=1, `clk_en_sec`=0 and `perf_level`=2'b00.
- R2: On the primary pipeline (`pipe_sel`=0, `fetch_stall`=0), the block stays put while `temp_pri` < high limit. The clock edge that samples `temp_pri` >= high limit enters the drain state.
- R3: The drain state shows `fetch_stall`=1, `pipe_sel`=0 and `clk_en_pri`=1. On entry, `flush_req` is high for exactly one cycle. The state is left only at an edge where `pipe_drained`=1, and the next state is the secondary pipeline.
- R4: On the secondary pipeline (`pipe_sel`=1, `clk_en_sec`=1, `fetch_stall`=0), `temp_pri` <= low limit returns to the primary pipeline. This check has priority over all others.
- R5: On the secondary pipeline with `temp_pri` > low limit, `temp_sec` >= high limit enters the throttle state. Otherwise the block stays on the secondary pipeline.
- R6: The throttle state is held while either reading is above the low limit. It returns to the primary pipeline when both readings are <= low limit.
- R7: The pipeline that is not selected has its clock enable low. `clk_en_pri` and `clk_en_sec` are never both 1.
- R8: With `STOP_CLOCK`=1, the throttle state drives `perf_level`=2'b11 and `fetch_stall`=1, with both clock enables 0. With `STOP_CLOCK`=0, it drives `perf_level`=`SCALE_LEVEL` and `fetch_stall`=0, with `clk_en_sec`=1. Every other state drives `perf_level`=2'b00.
- R9: The limits are sampled at every edge where `rst`=1 or the block is on the primary pipeline. Values presented in the drain, secondary or throttle states are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_pri | input | TW | Primary pipeline temperature, degrees C |
| temp_sec | input | TW | Secondary pipeline temperature, degrees C |
| thresh_lo | input | TW | Low (return) limit |
| thresh_hi | input | TW | High (switch) limit |
| pipe_drained | input | 1 | In-flight work has been cleared |
| fetch_stall | output | 1 | Hold instruction fetch |
| flush_req | output | 1 | One-cycle flush request |
| pipe_sel | output | 1 | 0 = primary, 1 = secondary pipeline |
| clk_en_pri | output | 1 | Primary pipeline clock enable |
| clk_en_sec | output | 1 | Secondary pipeline clock enable |
| perf_level | output | 2 | 00 full speed, 11 clock stopped, else scaled step |

## Verification
The hardest situation to reach is leaving the throttle state. It needs a path through drain and the secondary pipeline, and then both readings must be at or below the low limit at the same edge. A close second is a limit change that arrives while the block is off the primary pipeline and must have no effect. The random stimulus draws each temperature independently from cold, mid and hot bands around the current limits, so all four states are reached often, and it reprograms the limits at random moments. Directed steps first walk the exact boundary values (equal to each limit, and one off) and a limit change made on the secondary pipeline.

// File: rtl/thermal_sched_pkg.sv
package thermal_sched_pkg;
  typedef enum logic [1:0] {
    ST_PRI      = 2'd0,
    ST_DRAIN    = 2'd1,
    ST_SEC      = 2'd2,
    ST_THROTTLE = 2'd3
  } sched_state_e;

  localparam logic [1:0] PERF_FULL = 2'b00;
  localparam logic [1:0] PERF_STOP = 2'b11;
endpackage

// File: rtl/thermal_thresh_latch.sv
module thermal_thresh_latch #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic [TW-1:0] lo_in,
  input  logic [TW-1:0] hi_in,
  output logic [TW-1:0] lo_q,
  output logic [TW-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst || sample_en) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

  // Limits must not move while the block is off the primary pipeline.
  assert_limits_held_R9: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/thermal_sched_fsm.sv
module thermal_sched_fsm
  import thermal_sched_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp_pri,
  input  logic [TW-1:0] temp_sec,
  input  logic [TW-1:0] lim_lo,
  input  logic [TW-1:0] lim_hi,
  input  logic          drained,
  output sched_state_e  state_q,
  output sched_state_e  state_d
);
  logic pri_hot, pri_cool, sec_hot, sec_cool;

  assign pri_hot  = (temp_pri >= lim_hi);
  assign pri_cool = (temp_pri <= lim_lo);
  assign sec_hot  = (temp_sec >= lim_hi);
  assign sec_cool = (temp_sec <= lim_lo);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PRI:      if (pri_hot) state_d = ST_DRAIN;
      ST_DRAIN:    if (drained) state_d = ST_SEC;
      ST_SEC: begin
        if (pri_cool)     state_d = ST_PRI;
        else if (sec_hot) state_d = ST_THROTTLE;
      end
      ST_THROTTLE: if (pri_cool && sec_cool) state_d = ST_PRI;
      default:     state_d = ST_PRI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PRI;
    else     state_q <= state_d;
  end

  assert_pri_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRI && !pri_hot) |=> (state_q == ST_PRI));

  assert_drain_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN && !drained) |=> (state_q == ST_DRAIN));

  assert_sec_return_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEC && pri_cool) |=> (state_q == ST_PRI));

  assert_throttle_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_THROTTLE && $past(state_q) != ST_THROTTLE) |-> ($past(state_q) == ST_SEC));

  assert_throttle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_THROTTLE && !(pri_cool && sec_cool)) |=> (state_q == ST_THROTTLE));
endmodule

// File: rtl/thermal_sched_outreg.sv
module thermal_sched_outreg
  import thermal_sched_pkg::*;
#(
  parameter bit         STOP_CLOCK  = 1'b1,
  parameter logic [1:0] SCALE_LEVEL = 2'b01
) (
  input  logic         clk,
  input  logic         rst,
  input  sched_state_e state_q,
  input  sched_state_e state_d,
  output logic         fetch_stall,
  output logic         flush_req,
  output logic         pipe_sel,
  output logic         clk_en_pri,
  output logic         clk_en_sec,
  output logic [1:0]   perf_level
);
  localparam logic       THR_STALL  = STOP_CLOCK;
  localparam logic       THR_SEC_EN = !STOP_CLOCK;
  localparam logic [1:0] THR_LEVEL  = STOP_CLOCK ? PERF_STOP : SCALE_LEVEL;

  logic       stall_d, sel_d, pri_d, sec_d;
  logic [1:0] lvl_d;

  always_comb begin
    stall_d = 1'b0;
    sel_d   = 1'b0;
    pri_d   = 1'b1;
    sec_d   = 1'b0;
    lvl_d   = PERF_FULL;
    unique case (state_d)
      ST_DRAIN:    stall_d = 1'b1;
      ST_SEC: begin
        sel_d = 1'b1; pri_d = 1'b0; sec_d = 1'b1;
      end
      ST_THROTTLE: begin
        sel_d = 1'b1; pri_d = 1'b0; sec_d = THR_SEC_EN;
        stall_d = THR_STALL; lvl_d = THR_LEVEL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_stall <= 1'b0;
      flush_req   <= 1'b0;
      pipe_sel    <= 1'b0;
      clk_en_pri  <= 1'b1;
      clk_en_sec  <= 1'b0;
      perf_level  <= PERF_FULL;
    end else begin
      fetch_stall <= stall_d;
      flush_req   <= (state_d == ST_DRAIN) && (state_q != ST_DRAIN);
      pipe_sel    <= sel_d;
      clk_en_pri  <= pri_d;
      clk_en_sec  <= sec_d;
      perf_level  <= lvl_d;
    end
  end

  assert_flush_single_R3: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);

  assert_gate_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(clk_en_pri && clk_en_sec));

  assert_unselected_gated_R7: assert property (@(posedge clk) disable iff (rst)
    pipe_sel |-> !clk_en_pri);

  assert_level_only_off_primary_R8: assert property (@(posedge clk) disable iff (rst)
    (perf_level != PERF_FULL) |-> (pipe_sel && !clk_en_pri));
endmodule

// File: rtl/thermal_pipe_sched.sv
module thermal_pipe_sched
  import thermal_sched_pkg::*;
#(
  parameter int         TW          = 8,
  parameter bit         STOP_CLOCK  = 1'b1,
  parameter logic [1:0] SCALE_LEVEL = 2'b01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp_pri,
  input  logic [TW-1:0] temp_sec,
  input  logic [TW-1:0] thresh_lo,
  input  logic [TW-1:0] thresh_hi,
  input  logic          pipe_drained,
  output logic          fetch_stall,
  output logic          flush_req,
  output logic          pipe_sel,
  output logic          clk_en_pri,
  output logic          clk_en_sec,
  output logic [1:0]    perf_level
);
  sched_state_e  st_q, st_d;
  logic [TW-1:0] lim_lo, lim_hi;

  thermal_thresh_latch #(.TW(TW)) u_limits (
    .clk(clk), .rst(rst), .sample_en(st_q == ST_PRI),
    .lo_in(thresh_lo), .hi_in(thresh_hi), .lo_q(lim_lo), .hi_q(lim_hi)
  );

  thermal_sched_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst(rst), .temp_pri(temp_pri), .temp_sec(temp_sec),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .drained(pipe_drained),
    .state_q(st_q), .state_d(st_d)
  );

  thermal_sched_outreg #(.STOP_CLOCK(STOP_CLOCK), .SCALE_LEVEL(SCALE_LEVEL)) u_out (
    .clk(clk), .rst(rst), .state_q(st_q), .state_d(st_d),
    .fetch_stall(fetch_stall), .flush_req(flush_req), .pipe_sel(pipe_sel),
    .clk_en_pri(clk_en_pri), .clk_en_sec(clk_en_sec), .perf_level(perf_level)
  );
endmodule

// File: tb/test_thermal_pipe_sched.sv
module test_thermal_pipe_sched;
  localparam int         TW   = 8;
  localparam logic [1:0] SCL  = 2'b10;
  localparam int         PRI = 0, DRN = 1, SEC = 2, THR = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] t1 = '0, t2 = '0, lo = 8'd55, hi = 8'd70;
  logic          drn = 1'b0;

  logic       a_stall, a_flush, a_sel, a_enp, a_ens;
  logic [1:0] a_lvl;
  logic       b_stall, b_flush, b_sel, b_enp, b_ens;
  logic [1:0] b_lvl;

  int n_tests = 0, n_fail = 0;
  int m_state = PRI;
  int m_lo = 55, m_hi = 70;
  bit m_flush = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thermal_pipe_sched #(.TW(TW), .STOP_CLOCK(1'b1), .SCALE_LEVEL(SCL)) i_thermal_pipe_sched (
    .clk(clk), .rst(rst), .temp_pri(t1), .temp_sec(t2), .thresh_lo(lo), .thresh_hi(hi),
    .pipe_drained(drn), .fetch_stall(a_stall), .flush_req(a_flush), .pipe_sel(a_sel),
    .clk_en_pri(a_enp), .clk_en_sec(a_ens), .perf_level(a_lvl));

  thermal_pipe_sched #(.TW(TW), .STOP_CLOCK(1'b0), .SCALE_LEVEL(SCL)) i_thermal_pipe_sched_scale (
    .clk(clk), .rst(rst), .temp_pri(t1), .temp_sec(t2), .thresh_lo(lo), .thresh_hi(hi),
    .pipe_drained(drn), .fetch_stall(b_stall), .flush_req(b_flush), .pipe_sel(b_sel),
    .clk_en_pri(b_enp), .clk_en_sec(b_ens), .perf_level(b_lvl));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic string state_tag(input int s);
    case (s)
      PRI: return "R2";
      DRN: return "R3";
      SEC: return "R4";
      default: return "R6";
    endcase
  endfunction

  // Compare both variants against the model's expected outputs.
  task automatic check_outputs();
    string tg;
    int e_stall, e_sel, e_enp, e_ens_a, e_ens_b, e_lvl_a, e_lvl_b, e_stall_b;
    tg = state_tag(m_state);
    e_stall = (m_state == DRN || m_state == THR) ? 1 : 0;
    e_stall_b = (m_state == DRN) ? 1 : 0;
    e_sel = (m_state == SEC || m_state == THR) ? 1 : 0;
    e_enp = (m_state == PRI || m_state == DRN) ? 1 : 0;
    e_ens_a = (m_state == SEC) ? 1 : 0;
    e_ens_b = (m_state == SEC || m_state == THR) ? 1 : 0;
    e_lvl_a = (m_state == THR) ? 3 : 0;
    e_lvl_b = (m_state == THR) ? int'(SCL) : 0;
    chk(tg, "stop fetch_stall", int'(a_stall), e_stall);
    chk(tg, "stop pipe_sel", int'(a_sel), e_sel);
    chk("R3", "stop flush_req", int'(a_flush), int'(m_flush));
    chk("R7", "stop clk_en_pri", int'(a_enp), e_enp);
    chk("R7", "stop clk_en_sec", int'(a_ens), e_ens_a);
    chk("R8", "stop perf_level", int'(a_lvl), e_lvl_a);
    chk(tg, "scale fetch_stall", int'(b_stall), e_stall_b);
    chk(tg, "scale pipe_sel", int'(b_sel), e_sel);
    chk("R3", "scale flush_req", int'(b_flush), int'(m_flush));
    chk("R7", "scale clk_en_pri", int'(b_enp), e_enp);
    chk("R7", "scale clk_en_sec", int'(b_ens), e_ens_b);
    chk("R8", "scale perf_level", int'(b_lvl), e_lvl_b);
  endtask

  // Drive one cycle of inputs at a falling edge, advance the model, check at the next falling edge.
  task automatic step(input int p, input int s, input int l, input int h, input bit d);
    int nxt;
    t1 = 8'(p); t2 = 8'(s); lo = 8'(l); hi = 8'(h); drn = d;
    nxt = m_state;
    case (m_state)
      PRI: if (p >= m_hi) nxt = DRN;
      DRN: if (d) nxt = SEC;
      SEC: if (p <= m_lo) nxt = PRI; else if (s >= m_hi) nxt = THR;
      default: if (p <= m_lo && s <= m_lo) nxt = PRI;
    endcase
    m_flush = (nxt == DRN) && (m_state != DRN);
    if (m_state == PRI) begin
      m_lo = l; m_hi = h;            // R9: sampled only on the primary pipeline
    end
    m_state = nxt;
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  function automatic int pick_temp(input int l, input int h);
    int band;
    band = int'($urandom % 3);
    if (band == 0) return l - 5 + int'($urandom % 6);
    if (band == 1) return l + 1 + int'($urandom % (h - l - 1));
    return h + int'($urandom % 6);
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    int cl, ch;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state (model is PRI, no flush)
    m_state = PRI; m_flush = 1'b0; m_lo = 55; m_hi = 70;
    chk("R1", "reset fetch_stall", int'(a_stall), 0);
    chk("R1", "reset clk_en_pri", int'(a_enp), 1);
    chk("R1", "reset perf_level", int'(b_lvl), 0);
    check_outputs();
    rst = 1'b0;

    // Directed boundaries, gentle limits 55/70.
    step(69, 50, 55, 70, 1'b0);   // R2: one below high, stay primary
    step(70, 50, 55, 70, 1'b0);   // R2: equal to high, enter drain (R3 flush)
    step(75, 50, 55, 70, 1'b0);   // R3: no drained, hold, flush gone
    step(75, 50, 55, 70, 1'b1);   // R3: drained, go secondary
    step(60, 50, 80, 90, 1'b0);   // R9: limit change ignored, stays secondary
    step(56, 69, 55, 70, 1'b0);   // R5: stays secondary
    step(56, 70, 55, 70, 1'b0);   // R5: secondary hot -> throttle
    step(55, 56, 55, 70, 1'b0);   // R6: one still warm, hold
    step(60, 40, 55, 70, 1'b0);   // R6: hold
    step(55, 55, 55, 70, 1'b0);   // R6: both at low limit -> primary
    step(60, 50, 55, 60, 1'b0);   // R9: aggressive limits sampled on primary
    step(60, 50, 55, 60, 1'b0);   // R2: 60 >= 60 -> drain
    step(60, 50, 55, 60, 1'b1);   // R3: to secondary
    step(55, 99, 55, 60, 1'b0);   // R4: return has priority over hot secondary
    step(50, 50, 55, 60, 1'b0);

    // Constrained random phase.
    cl = 55; ch = 70;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 60) == 0) begin
        case ($urandom % 3)
          0: begin cl = 55; ch = 70; end
          1: begin cl = 55; ch = 60; end
          default: begin cl = 40; ch = 52; end
        endcase
      end
      step(pick_temp(m_lo, m_hi), pick_temp(m_lo, m_hi), cl, ch, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule